// File: doc/BRIEF.md
# Interrupt Priority Daisy Chain Controller

This block arbitrates among three internal interrupt sources that share one active-low CPU interrupt line. It joins a priority chain with external devices through an enable input (`iei`) and an enable output (`ieo`). It watches the CPU bus strobes to recognise interrupt-acknowledge cycles and opcode fetches. During an acknowledge it drives the vector of the winning source onto the data bus and marks that source as in service. During opcode fetches it recognises the two-byte return sequence (0xED, then 0x4D), which ends service of the highest-ranked in-service source.

A command register at address 14 chooses one of six rank orders for the three sources. Higher-ranked sources may interrupt lower-ranked sources that are in service. A source that is in service blocks every source ranked below it. After reset the block stays dormant until it has seen the machine-cycle strobe low. All bus strobes are sampled by `clk`, so they must stay stable for at least two clocks.

Top module: `irq_chain_ctrl`

## Requirements
- R1: After reset the block is dormant until it samples `m1_n` low. While dormant, `int_n` stays high and writes to the command register are ignored. The command register reads back 0 after reset.
- R2: The command register is written from `din[2:0]` when `cs_n` and `iorq_n` are low, `rd_n` and `m1_n` are high, and `addr` is 14. With `rd_n` low instead, the register is read: `dout` = {5'b0, order} and `dout_en` = 1.
- R3: Order code k (0..5) ranks the sources, highest first, as 0:{0,1,2}, 1:{0,2,1}, 2:{1,0,2}, 3:{1,2,0}, 4:{2,0,1}, 5:{2,1,0}. Codes 6 and 7 act as code 0 but read back unchanged.
- R4: `int_n` is low exactly when the block is active, `iei` is high, and some pending source is not outranked by an in-service source (the source itself included).
- R5: A cycle with `m1_n` and `iorq_n` both low is an acknowledge. From its second sampled clock, `dout_en` is 1 and `dout` carries the winner's byte from `src_vec` (source i at bits [8i+7:8i]). `src_ack` pulses one-hot for one clock, and the winner becomes in service.
- R6: `iei` is sampled when the acknowledge starts. If it is low, no vector is driven, no `src_ack` pulse occurs, and no source is put in service.
- R7: Pending requests are frozen while `m1_n` is low. A request that rises during an acknowledge is not served by that acknowledge.
- R8: `ieo` = `iei` AND no source in service AND (no source pending OR the last completed opcode fetch was 0xED).
- R9: An opcode fetch (`m1_n` and `rd_n` low, `iorq_n` high) of 0x4D that directly follows a fetch of 0xED clears the highest-ranked in-service source, provided `iei` is high. A 0x4D without the 0xED just before it has no effect.
- R10: A command write attempted while `m1_n` is low is ignored.
- R11: Service nests: a pending higher-ranked source raises `int_n` and wins while a lower one is in service. Successive return sequences release in-service sources from the highest rank down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| m1_n | input | 1 | Machine-cycle-one strobe, active low |
| addr | input | 4 | Register address |
| din | input | 8 | Data bus as seen by the block (writes and fetched opcodes) |
| dout | output | 8 | Data driven onto the bus |
| dout_en | output | 1 | Bus drive enable |
| src_req | input | 3 | Interrupt requests from the internal sources |
| src_vec | input | 24 | Vector bytes, source i in bits [8i+7:8i] |
| src_ack | output | 3 | One-clock acknowledge pulse to the served source |
| iei | input | 1 | Chain enable in, high = no higher device active |
| ieo | output | 1 | Chain enable out to lower devices |
| int_n | output | 1 | Shared interrupt request, active low |

## Verification
The hardest state to reach is two sources in service at once, with a third pending and blocked, followed by return sequences that must unwind them in rank order. The bench builds this by acknowledging a low-ranked source first, raising a higher one, and acknowledging it. It then raises the lowest source and runs return sequences one at a time, checking `int_n` after each. Two narrower windows get their own directed cycles: a request raised in the middle of an acknowledge, and broken return sequences (0xED followed by another opcode, or 0x4D alone).

// File: rtl/ic_pkg.sv
// Shared constants, types and the rank-order decoder for the
// interrupt chain controller. Assumes exactly three internal sources.
package ic_pkg;
    localparam int N_SRC   = 3;
    localparam int ORDER_W = 3;
    localparam int IDX_W   = 2;
    localparam logic [7:0] OP_PREFIX = 8'hED;
    localparam logic [7:0] OP_RETURN = 8'h4D;

    typedef logic [IDX_W-1:0] src_idx_t;

    // Source index placed at a given rank (0 = highest) by an order code.
    function automatic src_idx_t rank_src(input logic [ORDER_W-1:0] code, input int rank);
        logic [ORDER_W-1:0] c;
        src_idx_t first, lo, hi;
        c     = (code > 3'd5) ? 3'd0 : code;
        first = src_idx_t'(c >> 1);
        lo    = (first == 2'd0) ? 2'd1 : 2'd0;
        hi    = (first == 2'd2) ? 2'd1 : 2'd2;
        case (rank)
            0:       return first;
            1:       return c[0] ? hi : lo;
            default: return c[0] ? lo : hi;
        endcase
    endfunction
endpackage

// File: rtl/ic_bus_decode.sv
// Samples the CPU bus strobes once per clock and decodes acknowledge
// cycles, opcode-fetch completion, and command register access.
// Assumes strobes are synchronous to clk and held at least two clocks.
module ic_bus_decode
    import ic_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int CMD_ADDR = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               iorq_n,
    input  logic               rd_n,
    input  logic               m1_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  din,
    input  logic               iei,
    output logic               ack_start,
    output logic               in_ack,
    output logic               fetch_done,
    output logic [DATA_W-1:0]  op_byte,
    output logic               wr_cmd,
    output logic               rd_cmd,
    output logic [ORDER_W-1:0] cmd_data,
    output logic               m1_low,
    output logic               iei_s
);
    logic s_cs, s_iorq, s_rd, s_m1;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_din, op_q;
    logic ack_d, fetch_d, ack_now, fetch_now, io_sel;

    // Register every bus input once so all decoding sees one clean sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_cs <= 1'b1; s_iorq <= 1'b1; s_rd <= 1'b1; s_m1 <= 1'b1;
            s_addr <= '0; s_din <= '0; iei_s <= 1'b0;
        end else begin
            s_cs <= cs_n; s_iorq <= iorq_n; s_rd <= rd_n; s_m1 <= m1_n;
            s_addr <= addr; s_din <= din; iei_s <= iei;
        end
    end

    assign ack_now   = !s_m1 && !s_iorq;
    assign fetch_now = !s_m1 && !s_rd && s_iorq;

    // Previous-cycle cycle types for edge detection; capture the fetched byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_d <= 1'b0; fetch_d <= 1'b0; op_q <= '0;
        end else begin
            ack_d   <= ack_now;
            fetch_d <= fetch_now;
            if (fetch_now) op_q <= s_din;
        end
    end

    assign io_sel     = !s_cs && !s_iorq && s_m1 && (s_addr == ADDR_W'(CMD_ADDR));
    assign ack_start  = ack_now && !ack_d;
    assign in_ack     = ack_now;
    assign fetch_done = fetch_d && !fetch_now;
    assign op_byte    = op_q;
    assign wr_cmd     = io_sel && s_rd;
    assign rd_cmd     = io_sel && !s_rd;
    assign cmd_data   = s_din[ORDER_W-1:0];
    assign m1_low     = !s_m1;
endmodule

// File: rtl/ic_prio_walk.sv
// Walks the three sources in the programmed rank order. Reports the
// pending source that may be served next and the highest-ranked source
// in service. Purely combinational.
module ic_prio_walk
    import ic_pkg::*;
(
    input  logic [ORDER_W-1:0] order,
    input  logic [N_SRC-1:0]   pend,
    input  logic [N_SRC-1:0]   ius,
    output logic               win_valid,
    output src_idx_t           win_idx,
    output logic               top_valid,
    output src_idx_t           top_idx
);
    logic     blocked, seen_ius;
    src_idx_t s;

    // Rank walk: an in-service source blocks itself and everything below.
    always_comb begin
        blocked   = 1'b0;
        seen_ius  = 1'b0;
        win_valid = 1'b0;
        win_idx   = '0;
        top_valid = 1'b0;
        top_idx   = '0;
        s         = '0;
        for (int r = 0; r < N_SRC; r++) begin
            s = rank_src(order, r);
            if (!blocked) begin
                if (ius[s]) begin
                    blocked = 1'b1;
                end else if (pend[s]) begin
                    blocked   = 1'b1;
                    win_valid = 1'b1;
                    win_idx   = s;
                end
            end
            if (!seen_ius && ius[s]) begin
                seen_ius  = 1'b1;
                top_valid = 1'b1;
                top_idx   = s;
            end
        end
    end
endmodule

// File: rtl/irq_chain_ctrl.sv
// Interrupt priority daisy chain controller for three internal sources.
// Holds pending and in-service state, the rank-order command register,
// the chain enable output and the vector mux. Assumes bus strobes are
// synchronous to clk; reset is synchronous and active low.
module irq_chain_ctrl
    import ic_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 4,
    parameter int CMD_ADDR = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic                    iorq_n,
    input  logic                    rd_n,
    input  logic                    m1_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       din,
    output logic [DATA_W-1:0]       dout,
    output logic                    dout_en,
    input  logic [N_SRC-1:0]        src_req,
    input  logic [N_SRC*DATA_W-1:0] src_vec,
    output logic [N_SRC-1:0]        src_ack,
    input  logic                    iei,
    output logic                    ieo,
    output logic                    int_n
);
    logic ack_start, in_ack, fetch_done, wr_cmd, rd_cmd, m1_low, iei_s;
    logic [DATA_W-1:0]  op_byte, win_vec;
    logic [ORDER_W-1:0] cmd_data, order_q;
    logic [N_SRC-1:0]   pend_q, pend_eff, ius, src_ack_q;
    logic active, ed_seen, win_valid_q, take, ret_clr, drive_vec;
    logic win_valid, top_valid;
    src_idx_t win_idx, top_idx, win_q;

    ic_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_ADDR(CMD_ADDR)) u_dec (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .iorq_n(iorq_n), .rd_n(rd_n),
        .m1_n(m1_n), .addr(addr), .din(din), .iei(iei),
        .ack_start(ack_start), .in_ack(in_ack), .fetch_done(fetch_done),
        .op_byte(op_byte), .wr_cmd(wr_cmd), .rd_cmd(rd_cmd),
        .cmd_data(cmd_data), .m1_low(m1_low), .iei_s(iei_s)
    );

    ic_prio_walk u_walk (
        .order(order_q), .pend(pend_eff), .ius(ius),
        .win_valid(win_valid), .win_idx(win_idx),
        .top_valid(top_valid), .top_idx(top_idx)
    );

    assign pend_eff = active ? pend_q : '0;
    assign take     = ack_start && win_valid && iei_s;
    assign ret_clr  = fetch_done && (op_byte == OP_RETURN) && ed_seen && iei_s && top_valid;

    // Leave the dormant state once a machine-cycle strobe has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n) active <= 1'b0;
        else if (m1_low) active <= 1'b1;
    end

    // Sample requests, frozen while the machine-cycle strobe is low.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else if (m1_n) pend_q <= src_req;
    end

    // Command register: rank order, written only when active.
    always_ff @(posedge clk) begin
        if (!rst_n) order_q <= '0;
        else if (wr_cmd && active) order_q <= cmd_data;
    end

    // Acknowledge capture: latch the winner and pulse its acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_valid_q <= 1'b0; win_q <= '0; src_ack_q <= '0;
        end else begin
            src_ack_q <= '0;
            if (take) begin
                win_valid_q <= 1'b1;
                win_q       <= win_idx;
                src_ack_q   <= N_SRC'(1) << win_idx;
            end else if (!in_ack) begin
                win_valid_q <= 1'b0;
            end
        end
    end

    // In-service flags: set on acknowledge, cleared by the return sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) ius <= '0;
        else begin
            if (take)    ius[win_idx] <= 1'b1;
            if (ret_clr) ius[top_idx] <= 1'b0;
        end
    end

    // Track whether the last completed opcode fetch was the prefix byte.
    always_ff @(posedge clk) begin
        if (!rst_n) ed_seen <= 1'b0;
        else if (fetch_done) ed_seen <= (op_byte == OP_PREFIX);
    end

    // Vector mux and bus drive.
    always_comb begin
        win_vec   = src_vec[int'(win_q)*DATA_W +: DATA_W];
        drive_vec = in_ack && win_valid_q;
        dout_en   = !iorq_n && (drive_vec || rd_cmd);
        if (!dout_en)       dout = '0;
        else if (drive_vec) dout = win_vec;
        else                dout = {{(DATA_W-ORDER_W){1'b0}}, order_q};
    end

    assign src_ack = src_ack_q;
    assign ieo     = iei && !(|ius) && (ed_seen || !(|pend_eff));
    assign int_n   = !(iei && win_valid);
endmodule

// File: rtl/irq_chain_chk.sv
// Property checker for irq_chain_ctrl, attached through bind.
module irq_chain_chk
    import ic_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             m1_n,
    input logic             iei,
    input logic             ieo,
    input logic             int_n,
    input logic [N_SRC-1:0] src_ack
);
    logic seen_m1;

    // Own record of whether a machine-cycle strobe has appeared since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_m1 <= 1'b0;
        else if (!m1_n) seen_m1 <= 1'b1;
    end

    assert_dormant_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_m1 |-> int_n);
    assert_int_needs_iei_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !iei |-> int_n);
    assert_ack_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_ack));
    assert_ack_closes_chain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_ack) |-> !ieo);
    assert_ieo_needs_iei_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ieo |-> iei);
endmodule

bind irq_chain_ctrl irq_chain_chk u_chk (
    .clk(clk), .rst_n(rst_n), .m1_n(m1_n), .iei(iei),
    .ieo(ieo), .int_n(int_n), .src_ack(src_ack)
);

// File: tb/irq_chain_ctrl_bench.sv
module irq_chain_ctrl_bench;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1, iorq_n = 1, rd_n = 1, m1_n = 1, iei = 1;
    logic [3:0]  addr = '0;
    logic [7:0]  din = '0, dout;
    logic        dout_en, ieo, int_n;
    logic [2:0]  src_req = '0, src_ack;
    logic [23:0] src_vec = {8'hC2, 8'hB1, 8'hA0};
    int n_checks = 0, n_errors = 0, cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_chain_ctrl u_irq_chain_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .iorq_n(iorq_n), .rd_n(rd_n),
        .m1_n(m1_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .src_req(src_req), .src_vec(src_vec), .src_ack(src_ack),
        .iei(iei), .ieo(ieo), .int_n(int_n)
    );

    // {order code, requests, expected vector}
    localparam logic [13:0] TBL [8] = '{
        {3'd0, 3'b111, 8'hA0}, {3'd1, 3'b110, 8'hC2},
        {3'd2, 3'b101, 8'hA0}, {3'd3, 3'b101, 8'hC2},
        {3'd4, 3'b011, 8'hA0}, {3'd5, 3'b011, 8'hB1},
        {3'd5, 3'b100, 8'hC2}, {3'd6, 3'b110, 8'hB1}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); cs_n = 0; iorq_n = 0; rd_n = 1; m1_n = 1; addr = a; din = d;
        idle(2);
        cs_n = 1; iorq_n = 1;
        idle(1);
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] v, output logic e);
        @(negedge clk); cs_n = 0; iorq_n = 0; rd_n = 0; m1_n = 1; addr = a;
        idle(1);
        v = dout; e = dout_en;
        cs_n = 1; iorq_n = 1; rd_n = 1;
        idle(1);
    endtask

    task automatic intack(output logic [7:0] v, output logic e, output logic [2:0] ak);
        @(negedge clk); m1_n = 0;
        @(negedge clk); iorq_n = 0;
        idle(2);
        v = dout; e = dout_en; ak = src_ack;
        m1_n = 1; iorq_n = 1;
        idle(1);
    endtask

    task automatic fetch(input logic [7:0] op);
        @(negedge clk); m1_n = 0; rd_n = 0; din = op;
        idle(2);
        m1_n = 1; rd_n = 1;
        idle(3);
    endtask

    task automatic reti();
        fetch(8'hED);
        fetch(8'h4D);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 50000 && !done) begin
                n_errors++; n_checks++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 50000);
                $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] v;
        logic e;
        logic [2:0] ak;
        idle(4);
        rst_n = 1;
        idle(1);
        chk(int_n == 1, "R1 reset int_n", int_n, 1);
        chk(ieo == 1, "R8 reset ieo", ieo, 1);
        chk(dout_en == 0, "R1 reset dout_en", dout_en, 0);
        chk(src_ack == 0, "R5 reset src_ack", src_ack, 0);

        // R1: dormant until a machine-cycle strobe is seen
        src_req = 3'b001; idle(3);
        chk(int_n == 1, "R1 dormant int_n", int_n, 1);
        bus_write(4'd14, 8'd5);
        bus_read(4'd14, v, e);
        chk(e == 1 && v == 0, "R1 dormant write ignored", v, 0);
        fetch(8'h00);
        chk(int_n == 0, "R1 active after m1", int_n, 0);
        src_req = 0; idle(2);

        // Table walk: R2 readback, R3 ordering, R4 int, R5 ack, R9 return
        for (int i = 0; i < 8; i++) begin
            logic [2:0] ord, req;
            logic [7:0] ev;
            ord = TBL[i][13:11]; req = TBL[i][10:8]; ev = TBL[i][7:0];
            bus_write(4'd14, {5'b0, ord});
            bus_read(4'd14, v, e);
            chk(e == 1 && v == {5'b0, ord}, "R2 command readback", v, ord);
            src_req = req; idle(2);
            chk(int_n == 0, "R4 int_n asserted", int_n, 0);
            intack(v, e, ak);
            chk(e == 1 && v == ev, "R3 winner vector", v, ev);
            chk(ak == (3'b001 << ev[3:0]), "R5 ack pulse", ak, 3'b001 << ev[3:0]);
            src_req = 0; idle(2);
            chk(ieo == 0, "R8 ieo low in service", ieo, 0);
            reti();
            chk(ieo == 1 && int_n == 1, "R9 return clears service", {ieo, int_n}, 2'b11);
        end

        // R10: command write during machine-cycle low is ignored
        bus_write(4'd14, 8'd2);
        @(negedge clk); cs_n = 0; iorq_n = 0; rd_n = 1; m1_n = 0; addr = 4'd14; din = 8'd5;
        idle(3);
        chk(dout_en == 0, "R10 no drive in empty ack", dout_en, 0);
        cs_n = 1; iorq_n = 1; m1_n = 1;
        idle(1);
        bus_read(4'd14, v, e);
        chk(v == 8'd2, "R10 write with m1 low ignored", v, 2);
        bus_write(4'd14, 8'd0);

        // R6: enable-in low at acknowledge start
        src_req = 3'b001; iei = 0; idle(2);
        chk(int_n == 1, "R4 int_n blocked by iei", int_n, 1);
        intack(v, e, ak);
        chk(e == 0 && ak == 0, "R6 no vector with iei low", {e, ak}, 0);
        iei = 1; idle(2);
        chk(int_n == 0, "R6 source not put in service", int_n, 0);
        intack(v, e, ak);
        src_req = 0; reti();

        // R7: request raised mid-acknowledge is not served
        @(negedge clk); m1_n = 0;
        @(negedge clk); src_req = 3'b001; iorq_n = 0;
        idle(2);
        chk(dout_en == 0 && src_ack == 0, "R7 frozen request", {dout_en, src_ack}, 0);
        m1_n = 1; iorq_n = 1;
        idle(2);
        chk(int_n == 0, "R7 request seen after release", int_n, 0);

        // R8: pending source holds ieo low except right after the prefix byte
        chk(ieo == 0, "R8 pending closes chain", ieo, 0);
        fetch(8'hED);
        chk(ieo == 1, "R8 chain opens after prefix", ieo, 1);
        fetch(8'h00);
        chk(ieo == 0, "R8 chain closes again", ieo, 0);
        intack(v, e, ak);
        chk(v == 8'hA0 && e == 1, "R5 vector after freeze", v, 8'hA0);
        src_req = 0; idle(2);

        // R9: broken sequences and iei low do not end service
        fetch(8'h4D);
        chk(ieo == 0, "R9 lone return byte ignored", ieo, 0);
        fetch(8'hED); fetch(8'h00); fetch(8'h4D);
        chk(ieo == 0, "R9 interrupted sequence ignored", ieo, 0);
        iei = 0; reti(); iei = 1; idle(1);
        chk(ieo == 0, "R9 return ignored with iei low", ieo, 0);
        reti();
        chk(ieo == 1, "R9 full return clears", ieo, 1);

        // R11: nesting and unwinding
        src_req = 3'b010; idle(2);
        intack(v, e, ak);
        chk(v == 8'hB1, "R11 first service", v, 8'hB1);
        src_req = 3'b001; idle(2);
        chk(int_n == 0, "R11 higher may nest", int_n, 0);
        intack(v, e, ak);
        chk(v == 8'hA0 && ak == 3'b001, "R11 nested vector", v, 8'hA0);
        src_req = 3'b100; idle(2);
        chk(int_n == 1, "R11 lower blocked", int_n, 1);
        reti();
        chk(int_n == 1, "R11 still blocked by middle", int_n, 1);
        reti();
        chk(int_n == 0, "R11 released after unwind", int_n, 0);
        intack(v, e, ak);
        chk(v == 8'hC2, "R11 lowest served", v, 8'hC2);
        src_req = 0; reti();
        chk(ieo == 1 && int_n == 1, "R11 idle at end", {ieo, int_n}, 2'b11);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule